// File: doc/BRIEF.md
# Low-Power Mode Entry Controller

This block sequences a small microcontroller core between three power modes: Run, Sleep and Stop. It watches a wait request from the core and a return-from-handler strobe. It also watches the interrupt and event pending flags, the deep-sleep select, sleep-after-handler and ultra-low-power control bits, and the oscillator state. From these it decides whether a power-down may start and which mode it leads to. While the chip is down, it drives the clock gates, the oscillator enables, the flash power-down request, the enable for the reference and supervisors, and an I/O hold.

Leaving Sleep takes one cycle. Leaving Stop goes through a Wake phase. In that phase a counter covers the regulator start-up time, plus a programmable extra time when the flash was powered down. The system clock source is forced to the 16 MHz internal oscillator when Wake starts. A one-cycle ready pulse marks the return to Run. No reset is issued on entry or exit, so register and memory contents survive.

Top module: `pwrmode_ctrl`

## Requirements
- R1: After reset the mode is Run (mode code 0). `core_clk_en`, `dom_clk_en` and `ref_en` are high. `io_hold`, `flash_pd`, `wake_rdy` and `clk_src_force` are low.
- R2: A `wfi_req` in Run with `deep_sel`=0 and no pending interrupt moves the mode to Sleep (code 1) at the next clock edge. In Sleep, `core_clk_en` is low and `dom_clk_en` stays high.
- R3: An entry request is cancelled, and the mode stays Run, when `irq_pend` is high in the same cycle. A `wfi_req` with `wfe_mode`=1 is also cancelled while `evt_pend` is high.
- R4: A `handler_ret` strobe with `exit_sleep_en`=1, `deep_sel`=0 and no pending interrupt enters Sleep. With `exit_sleep_en`=0 the strobe has no effect.
- R5: Sleep returns to Run at the edge after `irq_pend` goes high. `evt_pend` also ends Sleep, but only when Sleep was entered with `wfe_mode`=1. Otherwise the event is ignored.
- R6: A request with `deep_sel`=1 enters Stop (code 2) only when `sys_on_int16` or `clk_fail_det_en` is high. Otherwise the request is ignored and the mode stays Run.
- R7: In Stop, `core_clk_en`, `dom_clk_en`, `pll_en`, `msi_en`, `hsi_en` and `hse_en` are all low and `io_hold` is high.
- R8: `ref_en` is low in Stop exactly when `ulp_en` was 1 at Stop entry. It is high again from the first Wake cycle. Later changes to `ulp_en` do not affect the Stop in progress.
- R9: `flash_pd` is high in Stop exactly when `flash_pd_en` was 1 at Stop entry. It is low in all other modes.
- R10: In Stop, `irq_pend` or `evt_pend` moves the mode to Wake (code 3). Wake lasts BASE_WAKE cycles, or BASE_WAKE + `extra_wait` cycles if the flash was powered down. During Wake, `core_clk_en` is low and `io_hold` is high.
- R11: `wake_rdy` is a one-cycle pulse in the first Run cycle after Wake.
- R12: `clk_src_force` is a one-cycle pulse in the first Wake cycle. `hsi_en` is high throughout Wake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wfi_req | input | 1 | Core wait request |
| wfe_mode | input | 1 | 1: the wait request is the wait-for-event form |
| handler_ret | input | 1 | Return-from-handler strobe |
| irq_pend | input | 1 | Interrupt pending |
| evt_pend | input | 1 | Event pending |
| deep_sel | input | 1 | 1: target is Stop, 0: target is Sleep |
| exit_sleep_en | input | 1 | Sleep on handler return |
| ulp_en | input | 1 | Shut off the reference in Stop |
| flash_pd_en | input | 1 | Power down the flash in Stop |
| extra_wait | input | EXTRA_W | Extra wake cycles after flash power-down |
| sys_on_int16 | input | 1 | System clock runs from the 16 MHz internal source |
| clk_fail_det_en | input | 1 | Clock-failure detection enabled |
| run_pll_en | input | 1 | Requested PLL enable |
| run_msi_en | input | 1 | Requested multi-speed oscillator enable |
| run_hsi_en | input | 1 | Requested 16 MHz internal oscillator enable |
| run_hse_en | input | 1 | Requested external oscillator enable |
| mode | output | 2 | 0 Run, 1 Sleep, 2 Stop, 3 Wake |
| core_clk_en | output | 1 | Core clock gate |
| dom_clk_en | output | 1 | Core-domain peripheral clock gate |
| pll_en | output | 1 | PLL enable |
| msi_en | output | 1 | Multi-speed oscillator enable |
| hsi_en | output | 1 | 16 MHz internal oscillator enable |
| hse_en | output | 1 | External oscillator enable |
| flash_pd | output | 1 | Flash power-down request |
| ref_en | output | 1 | Reference, brown-out, voltage-detector and temperature-sensor enable |
| io_hold | output | 1 | Hold I/O output states |
| clk_src_force | output | 1 | Pulse: switch the system clock to the 16 MHz internal source |
| wake_rdy | output | 1 | Pulse: wakeup complete |

## Verification
The entry decision is driven with plain wait requests and with the wait-for-event form. It is also driven with the handler-return strobe, with `exit_sleep_en` both set and cleared, and with an interrupt or event pending in the same cycle as the request. These cases separate the trigger path from the cancel path. Stop is tried with the oscillator precondition unmet, met through the internal clock, and met through failure detection. Stop-Wake round trips cover `ulp_en` and `flash_pd_en` both on and both off, so the latched reference and flash behaviour and the two wake durations show up at the ports. Sleep is left by an event after both entry forms, which separates the event-form latch from the interrupt-only exit.

// File: rtl/pwrmode_pkg.sv
// Shared types of the power-mode controller.
// Assumes: the mode code is visible at the top ports, so the encoding is fixed.
package pwrmode_pkg;
    typedef enum logic [1:0] {
        PM_RUN   = 2'd0,
        PM_SLEEP = 2'd1,
        PM_STOP  = 2'd2,
        PM_WAKE  = 2'd3
    } pm_state_e;

    localparam int unsigned N_OSC = 4;  // PLL, multi-speed, internal 16M, external
    localparam int unsigned OSC_HSI = 2;
endpackage

// File: rtl/pwrmode_gate.sv
// Entry decision: combines the wait and handler-return triggers with the
// cancel conditions and the oscillator precondition for Stop.
// Assumes: all inputs are synchronous to clk; used only while in Run.
module pwrmode_gate (
    input  logic wfi_req,
    input  logic wfe_mode,
    input  logic handler_ret,
    input  logic exit_sleep_en,
    input  logic irq_pend,
    input  logic evt_pend,
    input  logic deep_sel,
    input  logic sys_on_int16,
    input  logic clk_fail_det_en,
    output logic go_sleep,
    output logic go_stop,
    output logic ev_form
);
    logic trig_wait;
    logic trig_ret;
    logic trig_ok;
    logic osc_ok;

    // Qualify the triggers and pick the target mode.
    always_comb begin
        trig_wait = wfi_req && !(wfe_mode && evt_pend);
        trig_ret  = handler_ret && exit_sleep_en;
        trig_ok   = (trig_wait || trig_ret) && !irq_pend;
        osc_ok    = sys_on_int16 || clk_fail_det_en;
        go_sleep  = trig_ok && !deep_sel;
        go_stop   = trig_ok && deep_sel && osc_ok;
        ev_form   = trig_wait && wfe_mode;
    end
endmodule

// File: rtl/pwrmode_wake_timer.sv
// Wakeup delay counter: loaded on leaving Stop, counts down in Wake.
// Assumes: BASE_WAKE >= 1; expired is high when the count has run out.
module pwrmode_wake_timer #(
    parameter int unsigned BASE_WAKE = 4,
    parameter int unsigned EXTRA_W   = 6,
    parameter int unsigned CNT_W     = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               active,
    input  logic               flash_was_pd,
    input  logic [EXTRA_W-1:0] extra_wait,
    output logic               expired
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] base_c;
    logic [CNT_W-1:0] extra_c;

    // Start value: base minus one, plus the flash extra when it applies.
    always_comb begin
        base_c  = CNT_W'(BASE_WAKE - 1);
        extra_c = flash_was_pd ? CNT_W'(extra_wait) : '0;
    end

    // Load on Stop exit, then count down to zero during Wake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= base_c + extra_c;
        end else if (active && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/pwrmode_out_decode.sv
// Output decode: clock gates, oscillator enables, flash, reference, I/O hold.
// Assumes: state is registered, so the outputs are glitch-free per cycle.
module pwrmode_out_decode
    import pwrmode_pkg::*;
(
    input  pm_state_e        state,
    input  logic             ulp_lat,
    input  logic             flash_lat,
    input  logic [N_OSC-1:0] osc_req,
    output logic             core_clk_en,
    output logic             dom_clk_en,
    output logic [N_OSC-1:0] osc_en,
    output logic             flash_pd,
    output logic             ref_en,
    output logic             io_hold
);
    logic in_stop;
    logic in_wake;

    // Mode flags and gates shared by all outputs.
    always_comb begin
        in_stop     = (state == PM_STOP);
        in_wake     = (state == PM_WAKE);
        core_clk_en = (state == PM_RUN);
        dom_clk_en  = (state == PM_RUN) || (state == PM_SLEEP);
        flash_pd    = in_stop && flash_lat;
        ref_en      = !(in_stop && ulp_lat);
        io_hold     = in_stop || in_wake;
    end

    // One gate per oscillator: off in Stop; in Wake only the internal 16M runs.
    for (genvar i = 0; i < N_OSC; i++) begin : g_osc
        if (i == OSC_HSI) begin : g_hsi
            assign osc_en[i] = in_wake || (!in_stop && osc_req[i]);
        end else begin : g_other
            assign osc_en[i] = !in_stop && !in_wake && osc_req[i];
        end
    end
endmodule

// File: rtl/pwrmode_ctrl.sv
// Power-mode controller top: Run / Sleep / Stop / Wake sequencer.
// Assumes: synchronous active-low reset; pending flags are levels held by the
// interrupt controller; control bits are sampled when a mode is entered.
module pwrmode_ctrl
    import pwrmode_pkg::*;
#(
    parameter int unsigned BASE_WAKE = 4,
    parameter int unsigned EXTRA_W   = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wfi_req,
    input  logic               wfe_mode,
    input  logic               handler_ret,
    input  logic               irq_pend,
    input  logic               evt_pend,
    input  logic               deep_sel,
    input  logic               exit_sleep_en,
    input  logic               ulp_en,
    input  logic               flash_pd_en,
    input  logic [EXTRA_W-1:0] extra_wait,
    input  logic               sys_on_int16,
    input  logic               clk_fail_det_en,
    input  logic               run_pll_en,
    input  logic               run_msi_en,
    input  logic               run_hsi_en,
    input  logic               run_hse_en,
    output logic [1:0]         mode,
    output logic               core_clk_en,
    output logic               dom_clk_en,
    output logic               pll_en,
    output logic               msi_en,
    output logic               hsi_en,
    output logic               hse_en,
    output logic               flash_pd,
    output logic               ref_en,
    output logic               io_hold,
    output logic               clk_src_force,
    output logic               wake_rdy
);
    localparam int unsigned CNT_W = $clog2(BASE_WAKE + (1 << EXTRA_W));

    pm_state_e        state;
    pm_state_e        state_nx;
    logic             go_sleep;
    logic             go_stop;
    logic             ev_form;
    logic             ulp_lat;
    logic             flash_lat;
    logic             evform_lat;
    logic             stop_wake;
    logic             sleep_wake;
    logic             expired;
    logic [N_OSC-1:0] osc_req;
    logic [N_OSC-1:0] osc_en;

    pwrmode_gate u_gate (
        .wfi_req         (wfi_req),
        .wfe_mode        (wfe_mode),
        .handler_ret     (handler_ret),
        .exit_sleep_en   (exit_sleep_en),
        .irq_pend        (irq_pend),
        .evt_pend        (evt_pend),
        .deep_sel        (deep_sel),
        .sys_on_int16    (sys_on_int16),
        .clk_fail_det_en (clk_fail_det_en),
        .go_sleep        (go_sleep),
        .go_stop         (go_stop),
        .ev_form         (ev_form)
    );

    // Wake sources for each low-power mode.
    always_comb begin
        stop_wake  = irq_pend || evt_pend;
        sleep_wake = irq_pend || (evform_lat && evt_pend);
    end

    pwrmode_wake_timer #(
        .BASE_WAKE (BASE_WAKE),
        .EXTRA_W   (EXTRA_W),
        .CNT_W     (CNT_W)
    ) u_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .load         (state == PM_STOP && stop_wake),
        .active       (state == PM_WAKE),
        .flash_was_pd (flash_lat),
        .extra_wait   (extra_wait),
        .expired      (expired)
    );

    // Next-state selection of the mode sequencer.
    always_comb begin
        state_nx = state;
        unique case (state)
            PM_RUN: begin
                if (go_stop)       state_nx = PM_STOP;
                else if (go_sleep) state_nx = PM_SLEEP;
            end
            PM_SLEEP: if (sleep_wake) state_nx = PM_RUN;
            PM_STOP:  if (stop_wake)  state_nx = PM_WAKE;
            PM_WAKE:  if (expired)    state_nx = PM_RUN;
            default:  state_nx = PM_RUN;
        endcase
    end

    // State register and the control bits latched at mode entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= PM_RUN;
            ulp_lat    <= 1'b0;
            flash_lat  <= 1'b0;
            evform_lat <= 1'b0;
        end else begin
            state <= state_nx;
            if (state == PM_RUN && go_stop) begin
                ulp_lat   <= ulp_en;
                flash_lat <= flash_pd_en;
            end
            if (state == PM_RUN && go_sleep) begin
                evform_lat <= ev_form;
            end
        end
    end

    // Single-cycle pulses: clock-source force on Wake start, ready on Run return.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_src_force <= 1'b0;
            wake_rdy      <= 1'b0;
        end else begin
            clk_src_force <= (state == PM_STOP) && stop_wake;
            wake_rdy      <= (state == PM_WAKE) && expired;
        end
    end

    assign osc_req = {run_hse_en, run_hsi_en, run_msi_en, run_pll_en};

    pwrmode_out_decode u_dec (
        .state       (state),
        .ulp_lat     (ulp_lat),
        .flash_lat   (flash_lat),
        .osc_req     (osc_req),
        .core_clk_en (core_clk_en),
        .dom_clk_en  (dom_clk_en),
        .osc_en      (osc_en),
        .flash_pd    (flash_pd),
        .ref_en      (ref_en),
        .io_hold     (io_hold)
    );

    assign pll_en = osc_en[0];
    assign msi_en = osc_en[1];
    assign hsi_en = osc_en[2];
    assign hse_en = osc_en[3];
    assign mode   = state;
endmodule

// File: rtl/pwrmode_chk.sv
// Assertion checker for pwrmode_ctrl, attached by bind.
// Assumes: mode codes 0 Run, 1 Sleep, 2 Stop, 3 Wake.
module pwrmode_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wfi_req,
    input logic       wfe_mode,
    input logic       irq_pend,
    input logic       evt_pend,
    input logic       deep_sel,
    input logic       sys_on_int16,
    input logic       clk_fail_det_en,
    input logic [1:0] mode,
    input logic       core_clk_en,
    input logic       dom_clk_en,
    input logic       pll_en,
    input logic       msi_en,
    input logic       hsi_en,
    input logic       hse_en,
    input logic       io_hold,
    input logic       flash_pd,
    input logic       clk_src_force,
    input logic       wake_rdy
);
    a_r2_sleep_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd0 && wfi_req && !deep_sel && !irq_pend && !(wfe_mode && evt_pend))
        |=> mode == 2'd1);

    a_r3_cancel: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd0 && irq_pend) |=> mode == 2'd0);

    a_r5_sleep_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd1 && irq_pend) |=> mode == 2'd0);

    a_r6_osc_guard: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd2 && $past(mode) == 2'd0) |-> $past(sys_on_int16 || clk_fail_det_en));

    a_r7_stop_gates: assert property (@(posedge clk) disable iff (!rst_n)
        mode == 2'd2 |-> (!core_clk_en && !dom_clk_en && !pll_en && !msi_en
                          && !hsi_en && !hse_en && io_hold));

    a_r9_flash_only_stop: assert property (@(posedge clk) disable iff (!rst_n)
        flash_pd |-> mode == 2'd2);

    a_r10_wake_core_off: assert property (@(posedge clk) disable iff (!rst_n)
        mode == 2'd3 |-> (!core_clk_en && io_hold));

    a_r11_rdy_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        wake_rdy |-> (mode == 2'd0 && $past(mode) == 2'd3));

    a_r11_rdy_single: assert property (@(posedge clk) disable iff (!rst_n)
        wake_rdy |=> !wake_rdy);

    a_r12_force_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        clk_src_force |-> (mode == 2'd3 && $past(mode) == 2'd2 && hsi_en));
endmodule

bind pwrmode_ctrl pwrmode_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .wfi_req         (wfi_req),
    .wfe_mode        (wfe_mode),
    .irq_pend        (irq_pend),
    .evt_pend        (evt_pend),
    .deep_sel        (deep_sel),
    .sys_on_int16    (sys_on_int16),
    .clk_fail_det_en (clk_fail_det_en),
    .mode            (mode),
    .core_clk_en     (core_clk_en),
    .dom_clk_en      (dom_clk_en),
    .pll_en          (pll_en),
    .msi_en          (msi_en),
    .hsi_en          (hsi_en),
    .hse_en          (hse_en),
    .io_hold         (io_hold),
    .flash_pd        (flash_pd),
    .clk_src_force   (clk_src_force),
    .wake_rdy        (wake_rdy)
);

// File: tb/sim_pwrmode_ctrl.sv
// Directed bench for pwrmode_ctrl: one task per scenario, inputs driven and
// outputs sampled on the falling edge.
module sim_pwrmode_ctrl;
    localparam int BASE_WAKE = 4;
    localparam int EXTRA_W   = 6;

    logic clk = 1'b0;
    logic rst_n;
    logic wfi_req, wfe_mode, handler_ret, irq_pend, evt_pend, deep_sel;
    logic exit_sleep_en, ulp_en, flash_pd_en, sys_on_int16, clk_fail_det_en;
    logic run_pll_en, run_msi_en, run_hsi_en, run_hse_en;
    logic [EXTRA_W-1:0] extra_wait;
    logic [1:0] mode;
    logic core_clk_en, dom_clk_en, pll_en, msi_en, hsi_en, hse_en;
    logic flash_pd, ref_en, io_hold, clk_src_force, wake_rdy;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    pwrmode_ctrl #(.BASE_WAKE(BASE_WAKE), .EXTRA_W(EXTRA_W)) u0 (
        .clk(clk), .rst_n(rst_n), .wfi_req(wfi_req), .wfe_mode(wfe_mode),
        .handler_ret(handler_ret), .irq_pend(irq_pend), .evt_pend(evt_pend),
        .deep_sel(deep_sel), .exit_sleep_en(exit_sleep_en), .ulp_en(ulp_en),
        .flash_pd_en(flash_pd_en), .extra_wait(extra_wait),
        .sys_on_int16(sys_on_int16), .clk_fail_det_en(clk_fail_det_en),
        .run_pll_en(run_pll_en), .run_msi_en(run_msi_en),
        .run_hsi_en(run_hsi_en), .run_hse_en(run_hse_en),
        .mode(mode), .core_clk_en(core_clk_en), .dom_clk_en(dom_clk_en),
        .pll_en(pll_en), .msi_en(msi_en), .hsi_en(hsi_en), .hse_en(hse_en),
        .flash_pd(flash_pd), .ref_en(ref_en), .io_hold(io_hold),
        .clk_src_force(clk_src_force), .wake_rdy(wake_rdy)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic quiet();
        wfi_req = 0; wfe_mode = 0; handler_ret = 0; irq_pend = 0; evt_pend = 0;
        deep_sel = 0; exit_sleep_en = 0; ulp_en = 0; flash_pd_en = 0;
        sys_on_int16 = 0; clk_fail_det_en = 0; extra_wait = '0;
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    // Return from Sleep with an interrupt.
    task automatic leave_sleep();
        irq_pend = 1; step(); irq_pend = 0;
    endtask

    task automatic t_reset();
        check("R1 mode", mode, 0);
        check("R1 core_clk_en", core_clk_en, 1);
        check("R1 dom_clk_en", dom_clk_en, 1);
        check("R1 ref_en", ref_en, 1);
        check("R1 io_hold/flash_pd/rdy/force",
              {io_hold, flash_pd, wake_rdy, clk_src_force}, 0);
    endtask

    task automatic t_sleep_wfi();
        wfi_req = 1; step(); wfi_req = 0;
        check("R2 mode sleep", mode, 1);
        check("R2 core clk off", core_clk_en, 0);
        check("R2 domain clk on", dom_clk_en, 1);
        leave_sleep();
        check("R5 irq exits sleep", mode, 0);
    endtask

    task automatic t_cancel();
        wfi_req = 1; irq_pend = 1; step(); wfi_req = 0; irq_pend = 0;
        check("R3 irq cancels entry", mode, 0);
        wfi_req = 1; wfe_mode = 1; evt_pend = 1; step();
        wfi_req = 0; wfe_mode = 0; evt_pend = 0;
        check("R3 event cancels event-form entry", mode, 0);
    endtask

    task automatic t_handler_ret();
        handler_ret = 1; exit_sleep_en = 0; step(); handler_ret = 0;
        check("R4 return ignored without sleep-on-exit", mode, 0);
        handler_ret = 1; exit_sleep_en = 1; step(); handler_ret = 0; exit_sleep_en = 0;
        check("R4 return enters sleep", mode, 1);
        leave_sleep();
        check("R4 back to run", mode, 0);
    endtask

    task automatic t_event_exit();
        wfi_req = 1; wfe_mode = 1; step(); wfi_req = 0; wfe_mode = 0;
        check("R5 event-form sleep", mode, 1);
        evt_pend = 1; step(); evt_pend = 0;
        check("R5 event ends event-form sleep", mode, 0);
        wfi_req = 1; step(); wfi_req = 0;
        evt_pend = 1; step(); step(); evt_pend = 0;
        check("R5 event ignored in interrupt-form sleep", mode, 1);
        leave_sleep();
        check("R5 irq ends sleep", mode, 0);
    endtask

    task automatic t_osc_guard();
        deep_sel = 1; wfi_req = 1; step(); wfi_req = 0;
        check("R6 stop refused without clock precondition", mode, 0);
        check("R6 oscillators untouched", {pll_en, msi_en, hsi_en, hse_en}, 4'hF);
        clk_fail_det_en = 1; wfi_req = 1; step(); wfi_req = 0;
        check("R6 stop allowed with failure detection", mode, 2);
        evt_pend = 1; step(); evt_pend = 0;
        check("R10 event wakes stop", mode, 3);
        for (int i = 0; i < 20 && mode != 0; i++) step();
        check("R10 back to run", mode, 0);
        quiet();
    endtask

    // Full Stop round trip with the given latched controls.
    task automatic t_stop(input logic ulp, input logic fpd, input int extra);
        int n;
        int exp_len;
        exp_len = fpd ? BASE_WAKE + extra : BASE_WAKE;
        deep_sel = 1; sys_on_int16 = 1; ulp_en = ulp; flash_pd_en = fpd;
        extra_wait = EXTRA_W'(extra); wfi_req = 1; step(); wfi_req = 0;
        check("R7 mode stop", mode, 2);
        check("R7 clocks and oscillators off",
              {core_clk_en, dom_clk_en, pll_en, msi_en, hsi_en, hse_en}, 0);
        check("R7 io hold", io_hold, 1);
        check("R8 ref_en in stop", ref_en, !ulp);
        check("R9 flash_pd in stop", flash_pd, fpd);
        ulp_en = !ulp; flash_pd_en = !fpd; step();
        check("R8 ref_en latched at entry", ref_en, !ulp);
        check("R9 flash_pd latched at entry", flash_pd, fpd);
        irq_pend = 1; step(); irq_pend = 0;
        check("R10 mode wake", mode, 3);
        check("R12 force pulse first wake cycle", clk_src_force, 1);
        check("R12 hsi on in wake", hsi_en, 1);
        check("R8 ref_en back on wake", ref_en, 1);
        check("R10 core off / io hold in wake", {core_clk_en, io_hold}, 1);
        check("R9 flash_pd off in wake", flash_pd, 0);
        n = 1;
        step();
        check("R12 force is one cycle", clk_src_force, 0);
        while (mode == 3 && n < 200) begin
            n++;
            step();
        end
        check("R10 wake length", n, exp_len);
        check("R11 ready pulse", wake_rdy, 1);
        check("R11 run after wake", mode, 0);
        step();
        check("R11 ready is one cycle", wake_rdy, 0);
        quiet();
    endtask

    initial begin
        quiet();
        run_pll_en = 1; run_msi_en = 1; run_hsi_en = 1; run_hse_en = 1;
        rst_n = 0;
        repeat (3) step();
        rst_n = 1;
        step();
        t_reset();
        t_sleep_wfi();
        t_cancel();
        t_handler_ret();
        t_event_exit();
        t_osc_guard();
        t_stop(1'b1, 1'b1, 5);
        t_stop(1'b0, 1'b0, 5);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule